// File: doc/BRIEF.md
# RTC Alarm Wake Router

This block takes the one-cycle alarm pulse from a real-time clock and steers it to the wake and interrupt paths of the system. Control bits that a register interface supplies decide whether the alarm counts at all and which path it reaches. An alarm that counts always produces a single-cycle power-on request and sets a sticky status bit. While that status bit stays set, the routing bits choose between a level PME request and a level SMI request. Software clears the status bit by writing a one to it.

The block also covers the case where standby power is absent when the alarm fires. If the remember option is on, the alarm is held in a pending flag. On the first cycle with standby power present again, the pending alarm is replayed as if it had just fired. All outputs are registered and use a synchronous active-high reset.

Top module: `rtc_wake_router`

## Requirements
- R1: With `alarm_en`=0, an `alarm_evt` pulse has no effect: `pwr_on_req`, `alarm_sts`, `pme_req`, `smi_req` and `alarm_pending` all keep the values they would have without it.
- R2: An `alarm_evt` with `alarm_en`=1 and `stby_pwr_ok`=1 at a clock edge makes `pwr_on_req` 1 for exactly the next cycle and sets `alarm_sts` in that same next cycle.
- R3: `pme_req` is registered and equals the next `alarm_sts` value AND `sci_en`, both taken at the same edge. No other enable gates it.
- R4: `smi_req` is registered and equals the next `alarm_sts` value AND (`sci_en`=0) AND (`smi_sel`=0) AND (`smi_en`=1), all taken at the same edge.
- R5: `alarm_sts` stays set until an edge where `sts_wr`=1 and `sts_wdata`=1. A write with `sts_wdata`=0 leaves it set.
- R6: An `alarm_evt` with `alarm_en`=1, `remember_en`=1 and `stby_pwr_ok`=0 sets `alarm_pending` at the next cycle. While `stby_pwr_ok`=0, no power-on pulse is produced and `alarm_sts` is not set.
- R7: At an edge where `alarm_pending`=1, `stby_pwr_ok`=1 and `remember_en`=1, the next cycle has `pwr_on_req`=1, `alarm_sts`=1 and `alarm_pending`=0. The replay does not depend on `alarm_en`.
- R8: With `remember_en`=0 at an edge, `alarm_pending` is 0 at the next cycle and no replay takes place. An alarm with power absent and `remember_en`=0 is dropped.
- R9: When an alarm (new or replayed) and a clearing write meet at the same edge, `alarm_sts` is 1 afterwards.
- R10: While `rst` is 1 at an edge, all outputs are 0 at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_evt | input | 1 | One-cycle alarm pulse from the clock compare logic |
| alarm_en | input | 1 | Alarm counts when 1 |
| sci_en | input | 1 | Routes a set status bit to the PME request |
| smi_sel | input | 1 | 0 allows the SMI path when `sci_en` is 0 |
| smi_en | input | 1 | Enables the SMI path |
| remember_en | input | 1 | Keeps an alarm seen while standby power is off |
| stby_pwr_ok | input | 1 | Standby power present |
| sts_wr | input | 1 | Write strobe for the status bit |
| sts_wdata | input | 1 | Write data; 1 clears the status bit |
| pwr_on_req | output | 1 | One-cycle power-on request pulse |
| alarm_sts | output | 1 | Sticky alarm status |
| pme_req | output | 1 | Level PME request |
| smi_req | output | 1 | Level SMI request |
| alarm_pending | output | 1 | Alarm held for replay at power return |

## Verification
Two events can meet at the same edge: the setting of `alarm_sts` by an alarm or a replay, and its clearing by a one-write. The bench provokes this with a directed case, in which an alarm pulse and a clearing write go in together, and with a second directed case, in which a replay at power return meets a clearing write. Random stimulus adds more such meetings, since writes and alarms are drawn independently. In each case the bench model gives the set the priority, so the status must read 1 afterwards, and the PME or SMI level must follow the routing bits of that same edge.

// File: rtl/rtc_wk_pkg.sv
package rtc_wk_pkg;
  // Routing controls as seen by the wake router.
  typedef struct packed {
    logic alarm_en;
    logic sci_en;
    logic smi_sel;
    logic smi_en;
    logic remember_en;
  } wk_ctrl_t;

  // An alarm has to be routed to SMI only when SCI is off and SMI is selected.
  function automatic logic smi_route(input wk_ctrl_t c);
    return !c.sci_en && !c.smi_sel && c.smi_en;
  endfunction
endpackage

// File: rtl/rtc_wk_pending.sv
module rtc_wk_pending (
  input  logic clk,
  input  logic rst,
  input  logic alarm_evt,
  input  logic alarm_en,
  input  logic remember_en,
  input  logic pwr_ok,
  output logic pending,
  output logic replay
);
  logic pending_n;

  // Replay happens on any cycle with power present while a pending alarm is kept.
  assign replay = pending && pwr_ok && remember_en;

  always_comb begin
    pending_n = pending;
    if (!remember_en || pwr_ok) pending_n = 1'b0;
    else if (alarm_evt && alarm_en) pending_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= pending_n;
  end

  AST_REM_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !remember_en |=> !pending); // R8
  AST_PEND_NEEDS_ALARM: assert property (@(posedge clk) disable iff (rst)
    (!pending && !(alarm_evt && alarm_en)) |=> !pending); // R6
endmodule

// File: rtl/rtc_wk_status.sv
module rtc_wk_status (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic clr_wr,
  input  logic clr_data,
  output logic sts_n,
  output logic sts,
  output logic pulse
);
  // Set has priority over a same-cycle clear.
  assign sts_n = fire || (sts && !(clr_wr && clr_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      sts   <= 1'b0;
      pulse <= 1'b0;
    end else begin
      sts   <= sts_n;
      pulse <= fire;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (fire && clr_wr && clr_data) |=> sts); // R9
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (!fire && clr_wr && clr_data) |=> !sts); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts && !(clr_wr && clr_data)) |=> sts); // R5
endmodule

// File: rtl/rtc_wk_route.sv
module rtc_wk_route
  import rtc_wk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sts_n,
  input  wk_ctrl_t ctrl,
  output logic     pme_req,
  output logic     smi_req
);
  logic to_smi;
  assign to_smi = smi_route(ctrl);

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_req <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      pme_req <= sts_n && ctrl.sci_en;
      smi_req <= sts_n && to_smi;
    end
  end

  AST_PME_SMI_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pme_req && smi_req)); // R4
  AST_PME_FOLLOWS_SCI: assert property (@(posedge clk) disable iff (rst)
    (sts_n && ctrl.sci_en) |=> pme_req); // R3
endmodule

// File: rtl/rtc_wake_router.sv
module rtc_wake_router
  import rtc_wk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic alarm_evt,
  input  logic alarm_en,
  input  logic sci_en,
  input  logic smi_sel,
  input  logic smi_en,
  input  logic remember_en,
  input  logic stby_pwr_ok,
  input  logic sts_wr,
  input  logic sts_wdata,
  output logic pwr_on_req,
  output logic alarm_sts,
  output logic pme_req,
  output logic smi_req,
  output logic alarm_pending
);
  wk_ctrl_t ctrl;
  logic     replay;
  logic     live_alarm;
  logic     fire;
  logic     sts_n;

  assign ctrl = '{alarm_en: alarm_en, sci_en: sci_en, smi_sel: smi_sel,
                  smi_en: smi_en, remember_en: remember_en};

  assign live_alarm = alarm_evt && ctrl.alarm_en && stby_pwr_ok;
  assign fire       = live_alarm || replay;

  rtc_wk_pending u_pend (
    .clk(clk), .rst(rst), .alarm_evt(alarm_evt), .alarm_en(ctrl.alarm_en),
    .remember_en(ctrl.remember_en), .pwr_ok(stby_pwr_ok),
    .pending(alarm_pending), .replay(replay)
  );

  rtc_wk_status u_sts (
    .clk(clk), .rst(rst), .fire(fire), .clr_wr(sts_wr), .clr_data(sts_wdata),
    .sts_n(sts_n), .sts(alarm_sts), .pulse(pwr_on_req)
  );

  rtc_wk_route u_route (
    .clk(clk), .rst(rst), .sts_n(sts_n), .ctrl(ctrl),
    .pme_req(pme_req), .smi_req(smi_req)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (alarm_evt && !alarm_en && !(alarm_pending && stby_pwr_ok && remember_en))
      |=> !pwr_on_req); // R1
  AST_ENABLED_WAKE: assert property (@(posedge clk) disable iff (rst)
    (alarm_evt && alarm_en && stby_pwr_ok) |=> (pwr_on_req && alarm_sts)); // R2
  AST_NO_WAKE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    !stby_pwr_ok |=> !pwr_on_req); // R6
  AST_REPLAY: assert property (@(posedge clk) disable iff (rst)
    (alarm_pending && stby_pwr_ok && remember_en)
      |=> (pwr_on_req && alarm_sts && !alarm_pending)); // R7
  AST_PME_NEEDS_STS: assert property (@(posedge clk) disable iff (rst)
    pme_req |-> alarm_sts); // R3
  AST_SMI_NEEDS_STS: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> alarm_sts); // R4
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> !(pwr_on_req || alarm_sts || pme_req || smi_req || alarm_pending)); // R10
endmodule

// File: tb/rtc_wake_router_tb.sv
`timescale 1ns/1ps
module rtc_wake_router_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alarm_evt = 0, alarm_en = 0, sci_en = 0, smi_sel = 0, smi_en = 0;
  logic remember_en = 0, stby_pwr_ok = 1, sts_wr = 0, sts_wdata = 0;
  logic pwr_on_req, alarm_sts, pme_req, smi_req, alarm_pending;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic m_pulse = 0, m_sts = 0, m_pme = 0, m_smi = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  rtc_wake_router dut_i (
    .clk(clk), .rst(rst), .alarm_evt(alarm_evt), .alarm_en(alarm_en),
    .sci_en(sci_en), .smi_sel(smi_sel), .smi_en(smi_en),
    .remember_en(remember_en), .stby_pwr_ok(stby_pwr_ok),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .pwr_on_req(pwr_on_req),
    .alarm_sts(alarm_sts), .pme_req(pme_req), .smi_req(smi_req),
    .alarm_pending(alarm_pending)
  );

  function automatic logic exp_fire();
    return (alarm_evt && alarm_en && stby_pwr_ok) ||
           (m_pend && stby_pwr_ok && remember_en);
  endfunction

  function automatic logic exp_sts_next();
    return exp_fire() || (m_sts && !(sts_wr && sts_wdata));
  endfunction

  function automatic logic exp_pend_next();
    if (!remember_en || stby_pwr_ok) return 1'b0;
    return m_pend || (alarm_evt && alarm_en);
  endfunction

  task automatic model_edge();
    logic f, s, p;
    if (rst) begin
      m_pulse = 0; m_sts = 0; m_pme = 0; m_smi = 0; m_pend = 0;
    end else begin
      f = exp_fire();
      s = exp_sts_next();
      p = exp_pend_next();
      m_pme   = s && sci_en;
      m_smi   = s && !sci_en && !smi_sel && smi_en;
      m_pulse = f;
      m_sts   = s;
      m_pend  = p;
    end
  endtask

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk((tag == "") ? "R2" : tag, "pwr_on_req", pwr_on_req, m_pulse);
    chk((tag == "") ? "R5" : tag, "alarm_sts", alarm_sts, m_sts);
    chk((tag == "") ? "R3" : tag, "pme_req", pme_req, m_pme);
    chk((tag == "") ? "R4" : tag, "smi_req", smi_req, m_smi);
    chk((tag == "") ? "R6" : tag, "alarm_pending", alarm_pending, m_pend);
  endtask

  task automatic idle();
    alarm_evt = 0; sts_wr = 0; sts_wdata = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    rst = 1; step("R10"); step("R10");
    rst = 0; idle();

    // R1: disabled alarm does nothing
    alarm_en = 0; sci_en = 1; alarm_evt = 1; step("R1");
    idle(); step("R1");

    // R2 and R3: enabled alarm, PME route
    alarm_en = 1; alarm_evt = 1; step("R2");
    idle(); step("R2");
    if (!pme_req) begin errors++; $display("FAIL R3 pme_req: actual=0 expected=1"); end
    checks++;

    // R5: write of 0 keeps status, write of 1 clears it
    sts_wr = 1; sts_wdata = 0; step("R5");
    sts_wdata = 1; step("R5");
    idle(); step("R5");

    // R4: SMI route
    sci_en = 0; smi_sel = 0; smi_en = 1; alarm_evt = 1; step("R4");
    idle(); step("R4");
    smi_sel = 1; step("R4");
    smi_sel = 0; sts_wr = 1; sts_wdata = 1; step("R4");
    idle();

    // R9: set and clear at the same edge
    sci_en = 1; alarm_evt = 1; sts_wr = 1; sts_wdata = 1; step("R9");
    idle(); sts_wr = 1; sts_wdata = 1; step("R9");
    idle();

    // R6 and R7: alarm while unpowered, replay on return (with a clear, R9)
    remember_en = 1; stby_pwr_ok = 0; alarm_evt = 1; step("R6");
    idle(); step("R6");
    alarm_en = 0; stby_pwr_ok = 1; sts_wr = 1; sts_wdata = 1; step("R7");
    idle(); step("R7");
    alarm_en = 1; sts_wr = 1; sts_wdata = 1; step("R7");
    idle();

    // R8: remember off drops the pending alarm and a later unpowered alarm
    stby_pwr_ok = 0; alarm_evt = 1; step("R8");
    idle(); remember_en = 0; step("R8");
    stby_pwr_ok = 1; step("R8");
    stby_pwr_ok = 0; alarm_evt = 1; step("R8");
    idle(); stby_pwr_ok = 1; step("R8");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      alarm_evt = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) begin
        alarm_en = ($urandom_range(0, 3) != 0);
        sci_en   = $urandom_range(0, 1);
        smi_sel  = $urandom_range(0, 1);
        smi_en   = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 39) == 0) stby_pwr_ok = ~stby_pwr_ok;
      if ($urandom_range(0, 31) == 0) remember_en = ($urandom_range(0, 7) != 0);
      sts_wr    = ($urandom_range(0, 9) == 0);
      sts_wdata = $urandom_range(0, 1);
      rst       = ($urandom_range(0, 999) == 0);
      step(rst ? "R10" : "");
    end
    rst = 0; idle(); step("");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule